// File: doc/BRIEF.md
# Physical Memory Protection Access Checker

The block decides whether one memory access may go ahead under a sixteen-entry physical memory protection scheme of the RISC-V kind. Each cycle it takes a byte address, the kind of access (load, store or instruction fetch) and the current privilege level. It also takes the full set of per-entry configuration bytes and address registers as flat vectors. The grant or refusal appears on a registered output one clock later.

Every entry selects one of four ways to match an address. An entry can be switched off. It can cover a naturally aligned four-byte word. It can cover a naturally aligned power-of-two block, whose size comes from the trailing ones of the address register. It can cover a top-of-range span whose lower bound is the raw address register of the entry below it. When several entries cover the address, the lowest-numbered entry alone decides. A clear lock bit exempts machine-level accesses from that entry's permissions. A set lock bit enforces them at every privilege level.

Address registers hold the byte address shifted right by two. Configuration byte layout: bit 0 read, bit 1 write, bit 2 execute, bits 4:3 matching mode (0 off, 1 top-of-range, 2 four-byte, 3 power-of-two), bits 6:5 unused, bit 7 lock. Entry n occupies bits 8n+7:8n of `cfg_flat` and bits 30n+29:30n of `addr_flat`.

Top module: `pmp_checker`

## Requirements
- R1: `chk_allow` is a register. It reflects the inputs present at the previous rising clock edge. While `rst_n` is low at an edge, it reads 0 (deny) after that edge.
- R2: An entry in mode 2 covers exactly the four bytes that start at its register value times four.
- R3: An entry in mode 3 with k trailing ones in its register (k counted from bit 0) covers an aligned block of 2^(k+3) bytes that contains the register value times four. A register of all ones covers the whole address space.
- R4: An entry n in mode 1 covers byte addresses a with base <= a < top, where top is register n times four. When base >= top, it covers nothing.
- R5: Entry 0 in mode 1 uses base 0.
- R6: An entry in mode 0 covers nothing. Its register still serves, taken raw, as the base for entry n+1 in mode 1. The same raw use applies when entry n is in mode 3.
- R7: When several entries cover the address, only the lowest-numbered one is consulted.
- R8: Privilege encoding is 0 user, 1 supervisor, 3 machine; 2 is treated as not machine. For a covering entry with lock 0, machine accesses are allowed, and other levels get that entry's permission bit.
- R9: For a covering entry with lock 1, the permission bit applies at machine level too.
- R10: When no entry covers the address, machine accesses are allowed and all other levels are denied.
- R11: Access type encoding is 0 read, 1 write, 2 execute; these select configuration bits 0, 1 and 2. Type 3 is denied at every level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_addr | input | ADDR_W | Byte address of the access |
| acc_type | input | 2 | 0 read, 1 write, 2 execute, 3 reserved |
| acc_priv | input | 2 | 0 user, 1 supervisor, 3 machine |
| cfg_flat | input | 8*NUM_REGIONS | Per-entry configuration bytes |
| addr_flat | input | (ADDR_W-2)*NUM_REGIONS | Per-entry address registers, byte address >> 2 |
| chk_allow | output | 1 | Registered grant (1) or refusal (0) |

## Verification
The bench aims at the edges of each matching mode. It probes the last byte inside and the first byte past a four-byte word, a 32-byte power-of-two block and a top-of-range span. An off-by-one in the mask or the compare would grant one word too many or too few there. It builds a top-of-range entry above a switched-off entry and then an empty span with base equal to top. A design that ignored a switched-off neighbour's register would refuse the span, and one that wrapped would grant the empty one. Overlapping entries with conflicting permissions and toggling a lock bit catch a wrong priority order and machine level wrongly exempted or enforced. Random configurations checked against a behavioural range model cover the rest.

// File: rtl/pmp_pkg.sv
// Package: shared encodings for the protection checker.
package pmp_pkg;
    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_TOR   = 2'd1,
        MODE_NA4   = 2'd2,
        MODE_NAPOT = 2'd3
    } match_mode_e;

    typedef struct packed {
        logic        lock;
        logic [1:0]  spare;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

    localparam logic [1:0] PRIV_MACHINE = 2'b11;
    localparam logic [1:0] ACC_RESERVED = 2'b11;
endpackage

// File: rtl/pmp_region_match.sv
// Module: pmp_region_match
// Decides whether one entry covers a word address.
// Assumes: addresses arrive as word addresses (byte address >> 2);
// prev_addr is the raw register of the entry below (zero for entry 0).
module pmp_region_match #(
    parameter int WA_W = 30
) (
    input  pmp_pkg::match_mode_e mode,
    input  logic [WA_W-1:0]      this_addr,
    input  logic [WA_W-1:0]      prev_addr,
    input  logic [WA_W-1:0]      word_addr,
    output logic                 hit
);
    logic [WA_W-1:0] care_mask;

    // Power-of-two mask: clears the trailing ones and the first zero above them.
    always_comb care_mask = ~(this_addr ^ (this_addr + 1'b1));

    // Per-mode coverage decision.
    always_comb begin
        unique case (mode)
            pmp_pkg::MODE_TOR:   hit = (word_addr >= prev_addr) && (word_addr < this_addr);
            pmp_pkg::MODE_NA4:   hit = (word_addr == this_addr);
            pmp_pkg::MODE_NAPOT: hit = ((word_addr ^ this_addr) & care_mask) == '0;
            default:             hit = 1'b0;
        endcase
    end
endmodule

// File: rtl/pmp_first_hit.sv
// Module: pmp_first_hit
// Finds the lowest-numbered set bit of a hit vector.
// Assumes: N >= 2; idx is meaningless when any_hit is low.
module pmp_first_hit #(
    parameter int N     = 16,
    parameter int IDX_W = $clog2(N)
) (
    input  logic [N-1:0]     hits,
    output logic             any_hit,
    output logic [IDX_W-1:0] idx
);
    // Scan downward so the lowest index is written last and wins.
    always_comb begin
        any_hit = |hits;
        idx     = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) idx = IDX_W'(i);
        end
    end
endmodule

// File: rtl/pmp_checker.sv
// Module: pmp_checker (top)
// Grants or refuses one access against NUM_REGIONS protection entries and
// registers the verdict. Assumes 4-byte granularity; the two low address
// bits do not take part in matching.
module pmp_checker #(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [ADDR_W-1:0]             acc_addr,
    input  logic [1:0]                    acc_type,
    input  logic [1:0]                    acc_priv,
    input  logic [8*NUM_REGIONS-1:0]      cfg_flat,
    input  logic [(ADDR_W-2)*NUM_REGIONS-1:0] addr_flat,
    output logic                          chk_allow
);
    import pmp_pkg::*;

    localparam int WA_W  = ADDR_W - 2;
    localparam int IDX_W = $clog2(NUM_REGIONS);

    entry_cfg_t        cfg   [NUM_REGIONS];
    logic [WA_W-1:0]   radr  [NUM_REGIONS];
    logic [NUM_REGIONS-1:0] hits;
    logic [2*NUM_REGIONS+1:0] unused_bits;
    logic              any_hit;
    logic [IDX_W-1:0]  win_idx;
    logic              allow_d;
    logic              is_machine;
    logic [2:0]        win_perm;

    assign unused_bits[1:0] = acc_addr[1:0];

    // Per-entry unpacking and matching.
    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_entry
        assign cfg[g]  = entry_cfg_t'(cfg_flat[8*g +: 8]);
        assign radr[g] = addr_flat[WA_W*g +: WA_W];
        assign unused_bits[2*g+2 +: 2] = cfg[g].spare;

        logic [WA_W-1:0] base;
        if (g == 0) begin : g_base0
            assign base = '0;
        end else begin : g_basen
            assign base = radr[g-1];
        end

        pmp_region_match #(.WA_W(WA_W)) u_match (
            .mode      (cfg[g].mode),
            .this_addr (radr[g]),
            .prev_addr (base),
            .word_addr (acc_addr[ADDR_W-1:2]),
            .hit       (hits[g])
        );
    end

    pmp_first_hit #(.N(NUM_REGIONS), .IDX_W(IDX_W)) u_first (
        .hits    (hits),
        .any_hit (any_hit),
        .idx     (win_idx)
    );

    // Verdict from the winning entry, privilege and access type.
    always_comb begin
        is_machine = (acc_priv == PRIV_MACHINE);
        win_perm   = {cfg[win_idx].x, cfg[win_idx].w, cfg[win_idx].r};
        if (acc_type == ACC_RESERVED)           allow_d = 1'b0;
        else if (!any_hit)                      allow_d = is_machine;
        else if (is_machine && !cfg[win_idx].lock) allow_d = 1'b1;
        else                                    allow_d = win_perm[acc_type];
    end

    // Output register with synchronous reset to deny.
    always_ff @(posedge clk) begin
        if (!rst_n) chk_allow <= 1'b0;
        else        chk_allow <= allow_d;
    end
endmodule

// File: rtl/pmp_checker_sva.sv
// Module: pmp_checker_sva
// Port-level properties of pmp_checker; attached by bind below.
module pmp_checker_sva #(
    parameter int NUM_REGIONS = 16,
    parameter int ADDR_W      = 32
) (
    input logic                          clk,
    input logic                          rst_n,
    input logic [ADDR_W-1:0]             acc_addr,
    input logic [1:0]                    acc_type,
    input logic [1:0]                    acc_priv,
    input logic [8*NUM_REGIONS-1:0]      cfg_flat,
    input logic [(ADDR_W-2)*NUM_REGIONS-1:0] addr_flat,
    input logic                          chk_allow
);
    logic all_off;
    logic any_locked;

    // Summaries of the configuration as seen at the ports.
    always_comb begin
        all_off    = 1'b1;
        any_locked = 1'b0;
        for (int i = 0; i < NUM_REGIONS; i++) begin
            if (cfg_flat[8*i+3 +: 2] != 2'd0) all_off = 1'b0;
            if (cfg_flat[8*i+7]) any_locked = 1'b1;
        end
    end

    a_r1_reset_deny: assert property (@(posedge clk) !rst_n |=> !chk_allow);

    a_r10_machine_default: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && acc_priv == 2'b11 && acc_type != 2'b11) |=> chk_allow);

    a_r10_lower_default: assert property (@(posedge clk) disable iff (!rst_n)
        (all_off && acc_priv != 2'b11) |=> !chk_allow);

    a_r8_machine_unlocked: assert property (@(posedge clk) disable iff (!rst_n)
        (!any_locked && acc_priv == 2'b11 && acc_type != 2'b11) |=> chk_allow);

    a_r11_reserved_type: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_type == 2'b11) |=> !chk_allow);
endmodule

bind pmp_checker pmp_checker_sva #(
    .NUM_REGIONS (NUM_REGIONS),
    .ADDR_W      (ADDR_W)
) u_sva (.*);

// File: tb/pmp_checker_test.sv
// Bench: behavioural range model compared with the registered verdict.
module pmp_checker_test;
    localparam int CLK_PERIOD = 10;
    localparam int NR = 16;
    localparam int AW = 32;
    localparam int WA = AW - 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [AW-1:0] acc_addr = '0;
    logic [1:0] acc_type = '0;
    logic [1:0] acc_priv = '0;
    logic [7:0] cfg [NR];
    logic [WA-1:0] adr [NR];
    logic [8*NR-1:0] cfg_flat;
    logic [WA*NR-1:0] addr_flat;
    logic chk_allow;

    int vectors = 0;
    int fails = 0;
    bit done = 0;
    bit pend_v = 0;
    bit pend_exp = 0;
    string pend_tag = "";

    always #(CLK_PERIOD/2) clk = ~clk;

    // Pack bench arrays onto the flat ports.
    always_comb begin
        for (int i = 0; i < NR; i++) begin
            cfg_flat[8*i +: 8]   = cfg[i];
            addr_flat[WA*i +: WA] = adr[i];
        end
    end

    pmp_checker #(.NUM_REGIONS(NR), .ADDR_W(AW)) uut (
        .clk(clk), .rst_n(rst_n), .acc_addr(acc_addr), .acc_type(acc_type),
        .acc_priv(acc_priv), .cfg_flat(cfg_flat), .addr_flat(addr_flat),
        .chk_allow(chk_allow)
    );

    // Reference: byte ranges per entry, first covering entry decides.
    function automatic bit model(bit rstv, longint a, int typ, int pv);
        longint lo, hi, sz;
        int t;
        bit hit;
        if (!rstv) return 1'b0;
        if (typ == 3) return 1'b0;
        for (int i = 0; i < NR; i++) begin
            hit = 0;
            case (cfg[i][4:3])
                2'd1: begin
                    lo = (i == 0) ? 0 : longint'(adr[i-1]) * 4;
                    hi = longint'(adr[i]) * 4;
                    hit = (a >= lo) && (a < hi);
                end
                2'd2: begin
                    lo = longint'(adr[i]) * 4;
                    hit = (a >= lo) && (a < lo + 4);
                end
                2'd3: begin
                    t = 0;
                    while (t < WA && adr[i][t]) t++;
                    sz = longint'(1) << (t + 3);
                    lo = (longint'(adr[i]) * 4) & ~(sz - 1);
                    hit = (a >= lo) && (a < lo + sz);
                end
                default: hit = 0;
            endcase
            if (hit) begin
                if (pv == 3 && !cfg[i][7]) return 1'b1;
                return cfg[i][typ];
            end
        end
        return pv == 3;
    endfunction

    // Compare the pending vector, apply a new one, let it be registered.
    task automatic vec(input logic [AW-1:0] a, input int typ, input int pv, input string tag);
        @(negedge clk);
        if (pend_v) begin
            vectors++;
            if (chk_allow !== pend_exp) begin
                fails++;
                $display("FAIL %s: chk_allow=%0b expected=%0b", pend_tag, chk_allow, pend_exp);
            end
        end
        acc_addr = a;
        acc_type = 2'(typ);
        acc_priv = 2'(pv);
        pend_exp = model(rst_n, longint'(a), typ, pv);
        pend_tag = tag;
        pend_v = 1;
        @(posedge clk);
        #1;
    endtask

    task automatic clear_all();
        for (int i = 0; i < NR; i++) begin
            cfg[i] = 8'h00;
            adr[i] = '0;
        end
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        clear_all();
        cfg[0] = 8'h0F; adr[0] = 30'h40;
        // R1: deny while reset is held, even for machine level.
        vec(32'h0, 0, 3, "R1 reset");
        vec(32'h0, 0, 3, "R1 reset");
        rst_n = 1'b1;
        clear_all();
        // R10: no covering entry.
        vec(32'h1234, 0, 3, "R10 machine default");
        vec(32'h1234, 0, 0, "R10 user default");
        vec(32'h1234, 2, 1, "R10 supervisor default");
        // R2: four-byte entry 2 at 0x1000, read only.
        cfg[2] = 8'h11; adr[2] = 30'h400;
        vec(32'h1000, 0, 0, "R2 first byte");
        vec(32'h1003, 0, 0, "R2 last byte");
        vec(32'h1004, 0, 0, "R2 past end");
        vec(32'h0FFC, 0, 0, "R2 below");
        vec(32'h1000, 1, 0, "R8 write not permitted");
        vec(32'h1000, 1, 3, "R8 machine unlocked");
        // R3: power-of-two entry 3, 32 bytes at 0x2000, all permissions.
        cfg[3] = 8'h1F; adr[3] = (30'h2000 >> 2) | 30'h3;
        vec(32'h2000, 1, 0, "R3 block start");
        vec(32'h201F, 1, 0, "R3 block end");
        vec(32'h2020, 1, 0, "R3 past block");
        vec(32'h1FFC, 1, 0, "R3 below block");
        // R4/R6: entry 4 off holds base, entry 5 top-of-range, execute only.
        cfg[4] = 8'h00; adr[4] = 30'h3000 >> 2;
        cfg[5] = 8'h0C; adr[5] = 30'h3100 >> 2;
        vec(32'h3000, 2, 0, "R6 off entry base");
        vec(32'h30FC, 2, 0, "R4 last word");
        vec(32'h3100, 2, 0, "R4 top excluded");
        vec(32'h2FFC, 2, 0, "R4 below base");
        vec(32'h3000, 0, 0, "R4 read not permitted");
        vec(32'h3000, 2, 0, "R6 off entry itself");
        adr[5] = 30'h3000 >> 2;
        vec(32'h3000, 2, 0, "R4 empty span");
        // R6: power-of-two entry 3 raw register as base for entry 4.
        cfg[4] = 8'h0C; adr[4] = 30'h2100 >> 2;
        vec(32'h2020, 2, 0, "R6 raw base past decoded block");
        vec(32'h200C, 2, 0, "R6 raw base word");
        vec(32'h2008, 2, 0, "R6 inside block only");
        // R5: entry 0 top-of-range from zero, read only.
        cfg[0] = 8'h09; adr[0] = 30'h40;
        vec(32'h0000, 0, 0, "R5 base zero");
        vec(32'h00FC, 0, 1, "R5 last word");
        vec(32'h0100, 0, 0, "R5 top excluded");
        // R7: entry 1 no-access over 0x50 loses to entry 0.
        cfg[1] = 8'h10; adr[1] = 30'h50 >> 2;
        vec(32'h0050, 0, 0, "R7 lower entry wins");
        cfg[6] = 8'h13; adr[6] = 30'h400;
        vec(32'h1000, 1, 0, "R7 entry 2 over entry 6");
        // R9: lock entry 2, machine write refused, read granted.
        cfg[2] = 8'h91;
        vec(32'h1000, 1, 3, "R9 locked machine write");
        vec(32'h1000, 0, 3, "R9 locked machine read");
        cfg[2] = 8'h11;
        vec(32'h1000, 1, 3, "R8 unlocked again");
        // R11: reserved access type.
        vec(32'h2000, 3, 3, "R11 reserved machine");
        vec(32'h2000, 3, 0, "R11 reserved user");
        // R3: all-ones register covers everything.
        clear_all();
        cfg[7] = 8'h1A; adr[7] = '1;
        vec(32'hFFFF_FFFC, 1, 0, "R3 whole space top");
        vec(32'h0000_0000, 0, 0, "R3 whole space read denied");
        // Random configurations.
        for (int n = 0; n < 3000; n++) begin
            logic [AW-1:0] a;
            int k;
            if (n % 40 == 0) begin
                for (int i = 0; i < NR; i++) begin
                    cfg[i] = 8'($urandom);
                    adr[i] = WA'($urandom) & ((n % 80 == 0) ? 30'h0000_0FFF : 30'h3FFF_FFFF);
                    if ($urandom_range(0, 3) == 0) adr[i] = adr[i] | 30'h7;
                end
            end
            k = int'($urandom_range(0, NR - 1));
            if ($urandom_range(0, 1) == 1) a = {adr[k], 2'b00} + AW'($urandom_range(0, 40)) - 32'd16;
            else a = AW'($urandom);
            vec(a, int'($urandom_range(0, 3)), int'($urandom_range(0, 3)), "R7 random mix");
        end
        vec(32'h0, 0, 0, "flush");
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule